// File: doc/BRIEF.md
# Interrupt Context Shadow Save and Restore Unit

This unit sits beside the fetch stage of a small 8-bit controller core and handles the core state around a single interrupt. When a request is taken, it captures the 12-bit program counter and the working, status and file-select registers in one clock edge. It also tells the fetch stage to load the vector address 000h. Later the core decodes the return opcode. The unit then runs a short fixed-length return sequence and holds fetch stalled while it runs. On the final cycle it hands all four saved values back, so execution resumes at the interrupted instruction.

There is only one level of shadow storage. While a handler is running, the unit does not take new requests. A request held by the requester is taken on the first cycle after the return has finished. The return length depends on the execution mode. Compatible mode takes two cycles and turbo mode takes three. The mode is sampled when the return opcode is decoded.

Top module: `irq_ctx_shadow`

## Requirements
- R1: While rst_n is low, irq_ack, pc_load, ctx_load and busy are all 0 and in_service is 0, even with irq_req high.
- R2: With irq_req high, in_service 0 and busy 0, irq_ack and pc_load are 1 in that same cycle with pc_next = 12'h000. in_service is 1 from the next cycle on.
- R3: The pc_live, w_live, status_live and fsr_live values present in the accept cycle are the values given back at restore. Later changes to those inputs have no effect on what is given back.
- R4: A return starts only when ret_valid is 1, ret_opcode equals 12'h00E and in_service is 1. Any other opcode value leaves busy at 0 and in_service at 1.
- R5: With turbo_mode 0 at decode, busy is 1 for exactly 2 cycles after the decode cycle, and ctx_load is 1 on the second of them.
- R6: With turbo_mode 1 at decode, busy is 1 for exactly 3 cycles after the decode cycle, and ctx_load is 1 on the third of them.
- R7: In the ctx_load cycle, pc_load is 1, pc_next equals the saved PC, and w_rest, status_rest and fsr_rest equal the saved bytes. All 8 status bits are restored. In the following cycle, busy and in_service are 0.
- R8: While in_service or busy is 1, irq_ack stays 0. A request still held is acknowledged in the first cycle after the restore cycle.
- R9: The return opcode presented while in_service is 0 is ignored: busy stays 0.
- R10: Changing turbo_mode while busy is 1 does not change the length of the return in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request level, held by the requester until acknowledged |
| irq_ack | output | 1 | Request accepted this cycle |
| ret_valid | input | 1 | ret_opcode carries a decoded instruction this cycle |
| ret_opcode | input | 12 | Instruction word from the decoder |
| turbo_mode | input | 1 | 1 = turbo (3-cycle return), 0 = compatible (2-cycle return) |
| pc_live | input | 12 | Current program counter |
| w_live | input | 8 | Current working register |
| status_live | input | 8 | Current status register |
| fsr_live | input | 8 | Current file-select register |
| pc_load | output | 1 | Fetch must load pc_next this cycle |
| pc_next | output | 12 | Vector on entry, saved PC on return |
| ctx_load | output | 1 | Core must load the three restored registers this cycle |
| w_rest | output | 8 | Restored working register, 0 when ctx_load is 0 |
| status_rest | output | 8 | Restored status register, 0 when ctx_load is 0 |
| fsr_rest | output | 8 | Restored file-select register, 0 when ctx_load is 0 |
| busy | output | 1 | Return in progress, fetch is stalled |
| in_service | output | 1 | A handler is running |

## Verification
A shadow register that captured on the wrong cycle, or that was overwritten while the handler ran, shows up as a wrong pc_next or a wrong restored byte. This appears in the single ctx_load cycle, two or three cycles after the return opcode. A return counter that is loaded wrongly shows up as a busy window of the wrong length, or as a ctx_load strobe that is late or missing. A stuck in-service flag shows up either as a duplicate irq_ack during a handler or as a held request that is never taken in the cycle after restore.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int PC_W = 12;
  localparam int DW   = 8;
  localparam int OP_W = 12;

  localparam logic [OP_W-1:0] RET_OPCODE = 12'h00E;
  localparam logic [PC_W-1:0] VECTOR_PC  = 12'h000;

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic [DW-1:0]   w;
    logic [DW-1:0]   status;
    logic [DW-1:0]   fsr;
  } ctx_t;

  function automatic logic is_ret_op(input logic [OP_W-1:0] op);
    return op == RET_OPCODE;
  endfunction

  function automatic int unsigned ret_cycles(input logic turbo,
                                             input int unsigned compat_c,
                                             input int unsigned turbo_c);
    return turbo ? turbo_c : compat_c;
  endfunction
endpackage

// File: rtl/ctx_shadow_bank.sv
module ctx_shadow_bank
  import irq_ctx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  ctx_t ctx_live,
  output ctx_t ctx_saved
);
  ctx_t shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      shadow_q <= '0;
    else if (cap_en) shadow_q <= ctx_live;
  end

  assign ctx_saved = shadow_q;

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(shadow_q));
  assert_shadow_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (shadow_q == $past(ctx_live)));
endmodule

// File: rtl/ctx_ret_seq.sv
module ctx_ret_seq
  import irq_ctx_pkg::*;
#(
  parameter int unsigned COMPAT_CYC = 2,
  parameter int unsigned TURBO_CYC  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_start,
  input  logic turbo_mode,
  output logic busy,
  output logic ret_done
);
  localparam int unsigned MAX_CYC = (COMPAT_CYC > TURBO_CYC) ? COMPAT_CYC : TURBO_CYC;
  localparam int CW = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign ret_done = busy_q && (cnt_q == '0);
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ret_start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(ret_cycles(turbo_mode, COMPAT_CYC, TURBO_CYC) - 1);
    end else if (ret_done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assert_busy_continues_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ret_done) |=> busy_q);
  assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |=> !busy_q);
  assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_start |-> !busy_q);
endmodule

// File: rtl/ctx_entry_ctl.sv
module ctx_entry_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic busy,
  input  logic ret_done,
  output logic accept,
  output logic in_service
);
  logic svc_q;

  assign accept     = rst_n && irq_req && !svc_q && !busy;
  assign in_service = svc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        svc_q <= 1'b0;
    else if (accept)   svc_q <= 1'b1;
    else if (ret_done) svc_q <= 1'b0;
  end

  assert_accept_sets_svc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> svc_q);
  assert_busy_inside_svc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> svc_q);
  assert_done_clears_svc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |=> !svc_q);
endmodule

// File: rtl/irq_ctx_shadow.sv
module irq_ctx_shadow
  import irq_ctx_pkg::*;
#(
  parameter int unsigned COMPAT_CYC = 2,
  parameter int unsigned TURBO_CYC  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  output logic            irq_ack,
  input  logic            ret_valid,
  input  logic [OP_W-1:0] ret_opcode,
  input  logic            turbo_mode,
  input  logic [PC_W-1:0] pc_live,
  input  logic [DW-1:0]   w_live,
  input  logic [DW-1:0]   status_live,
  input  logic [DW-1:0]   fsr_live,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_next,
  output logic            ctx_load,
  output logic [DW-1:0]   w_rest,
  output logic [DW-1:0]   status_rest,
  output logic [DW-1:0]   fsr_rest,
  output logic            busy,
  output logic            in_service
);
  ctx_t ctx_live, ctx_saved;
  logic accept, ret_hit, ret_done, busy_w, svc_w;

  assign ctx_live = '{pc: pc_live, w: w_live, status: status_live, fsr: fsr_live};
  assign ret_hit  = ret_valid && is_ret_op(ret_opcode) && svc_w && !busy_w;

  ctx_entry_ctl u_entry (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .busy(busy_w),
    .ret_done(ret_done), .accept(accept), .in_service(svc_w)
  );

  ctx_shadow_bank u_bank (
    .clk(clk), .rst_n(rst_n), .cap_en(accept),
    .ctx_live(ctx_live), .ctx_saved(ctx_saved)
  );

  ctx_ret_seq #(.COMPAT_CYC(COMPAT_CYC), .TURBO_CYC(TURBO_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .ret_start(ret_hit), .turbo_mode(turbo_mode),
    .busy(busy_w), .ret_done(ret_done)
  );

  assign irq_ack     = accept;
  assign pc_load     = accept || ret_done;
  assign pc_next     = ret_done ? ctx_saved.pc : VECTOR_PC;
  assign ctx_load    = ret_done;
  assign w_rest      = ret_done ? ctx_saved.w      : '0;
  assign status_rest = ret_done ? ctx_saved.status : '0;
  assign fsr_rest    = ret_done ? ctx_saved.fsr    : '0;
  assign busy        = busy_w;
  assign in_service  = svc_w;

  assert_busy_from_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_w) |-> $past(ret_hit));
  assert_ack_vectors_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (pc_load && !ctx_load));
  assert_no_ack_in_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_w |-> !irq_ack);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!irq_ack && !ctx_load));
endmodule

// File: tb/irq_ctx_shadow_bench.sv
module irq_ctx_shadow_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, ret_valid = 1'b0, turbo_mode = 1'b0;
  logic [11:0] ret_opcode = '0, pc_live = '0;
  logic [7:0]  w_live = '0, status_live = '0, fsr_live = '0;
  logic        irq_ack, pc_load, ctx_load, busy, in_service;
  logic [11:0] pc_next;
  logic [7:0]  w_rest, status_rest, fsr_rest;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irq_ctx_shadow u_irq_ctx_shadow (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .ret_valid(ret_valid), .ret_opcode(ret_opcode), .turbo_mode(turbo_mode),
    .pc_live(pc_live), .w_live(w_live), .status_live(status_live), .fsr_live(fsr_live),
    .pc_load(pc_load), .pc_next(pc_next), .ctx_load(ctx_load),
    .w_rest(w_rest), .status_rest(status_rest), .fsr_rest(fsr_rest),
    .busy(busy), .in_service(in_service)
  );

  // {turbo, pc, w, status, fsr}
  localparam logic [36:0] VEC [6] = '{
    {1'b0, 12'h123, 8'hA5, 8'hFF, 8'h3C},
    {1'b1, 12'hFFF, 8'h00, 8'h00, 8'hFF},
    {1'b0, 12'h000, 8'h5A, 8'h81, 8'h01},
    {1'b1, 12'h800, 8'hFF, 8'h7E, 8'h80},
    {1'b1, 12'h001, 8'h11, 8'h18, 8'hC3},
    {1'b0, 12'hABC, 8'h96, 8'h24, 8'h42}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Count cycles from the decode edge until ctx_load; returns count (0 = none in limit).
  task automatic wait_restore(output int n, input logic flip_mode);
    n = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i == 1 && flip_mode) turbo_mode = ~turbo_mode;
      #0.5;
      if (ctx_load) begin n = i; break; end
    end
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // R1: reset holds everything idle even with a request present
    irq_req = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    chk(irq_ack == 0 && pc_load == 0, "R1 ack/pc_load in reset", irq_ack, 0);
    chk(busy == 0 && in_service == 0 && ctx_load == 0, "R1 busy/svc in reset", {busy, in_service}, 0);
    irq_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: return opcode with no handler running is ignored
    ret_valid = 1'b1; ret_opcode = 12'h00E;
    @(negedge clk);
    ret_valid = 1'b0;
    #0.5;
    chk(busy == 0 && in_service == 0, "R9 stray return", busy, 0);

    // Vector table: entry, save, return, restore
    for (int v = 0; v < 6; v++) begin
      logic [36:0] e;
      int exp_n;
      e = VEC[v];
      exp_n = e[36] ? 3 : 2;
      @(negedge clk);
      turbo_mode = e[36];
      {pc_live, w_live, status_live, fsr_live} = e[35:0];
      irq_req = 1'b1;
      #0.5;
      chk(irq_ack == 1 && pc_load == 1 && pc_next == 12'h000, "R2 accept/vector", pc_next, 0);
      @(negedge clk);
      irq_req = 1'b0;
      {pc_live, w_live, status_live, fsr_live} = ~e[35:0];
      #0.5;
      chk(in_service == 1 && busy == 0, "R2 in service", in_service, 1);
      ret_valid = 1'b1; ret_opcode = 12'h00E;
      @(negedge clk);
      ret_valid = 1'b0;
      #0.5;
      chk(busy == 1, "R4 return started", busy, 1);
      // back up: wait_restore counts from the decode edge; first busy cycle already here
      if (ctx_load) n = 1;
      else begin
        wait_restore(n, 1'b1);
        n = n + 1;
        if (n == 1) n = 0;
      end
      if (e[36]) chk(n == exp_n, "R6 turbo length/R10", n, exp_n);
      else       chk(n == exp_n, "R5 compat length/R10", n, exp_n);
      chk(pc_load && pc_next == e[35:24], "R7 restored pc R3", pc_next, e[35:24]);
      chk({w_rest, status_rest, fsr_rest} == e[23:0], "R7 restored regs R3",
          {w_rest, status_rest, fsr_rest}, e[23:0]);
      @(negedge clk);
      #0.5;
      chk(busy == 0 && in_service == 0, "R7 idle after restore", {busy, in_service}, 0);
    end

    // R4: wrong opcodes while in service are ignored
    @(negedge clk);
    turbo_mode = 1'b0;
    {pc_live, w_live, status_live, fsr_live} = {12'h456, 8'h12, 8'h34, 8'h56};
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    foreach (VEC[k]) begin
      ret_valid = 1'b1;
      ret_opcode = 12'h00F ^ 12'(k << 4);
      @(negedge clk);
    end
    ret_valid = 1'b0;
    #0.5;
    chk(busy == 0 && in_service == 1, "R4 other opcodes ignored", {busy, in_service}, 1);

    // R8: held request waits through the handler and the return
    irq_req = 1'b1;
    #0.5;
    chk(irq_ack == 0, "R8 no ack in service", irq_ack, 0);
    ret_valid = 1'b1; ret_opcode = 12'h00E;
    @(negedge clk);
    ret_valid = 1'b0;
    #0.5;
    chk(irq_ack == 0 && busy == 1, "R8 no ack while busy", irq_ack, 0);
    @(negedge clk);
    #0.5;
    chk(ctx_load == 1 && irq_ack == 0, "R5 compat restore R8", {ctx_load, irq_ack}, 2);
    chk(pc_next == 12'h456 && status_rest == 8'h34, "R7 restore second handler", pc_next, 12'h456);
    @(negedge clk);
    #0.5;
    chk(irq_ack == 1 && pc_next == 12'h000, "R8 held request taken", irq_ack, 1);
    @(negedge clk);
    irq_req = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule